// File: doc/BRIEF.md
# Six-Function Compare ALU

This block is the arithmetic and logic unit of a small register-based processor. It takes two operand words and a three-bit operation select. In the same cycle it returns one result word and a zero flag. There is no clock and no state: the result follows the inputs through combinational logic only. The sequencer in the control path reads the result back into the register file or the data memory.

The control path also uses the zero flag to steer conditional branches. For both the branch-if-equal and the branch-if-not-equal instructions, the sequencer selects the subtract operation on the two compared registers. It then takes or skips the branch according to whether the difference is zero.

Besides add, subtract, AND and OR, the block offers two further functions. Decode turns the low bits of the first operand into a one-hot word. Set-on-less gives a result of 1 or 0 from an unsigned comparison. The two unused select codes return zero. The block has no states and no transitions. Its only "mode" is the operation select, and each code is listed in the requirements below.

Top module: `alu6_core`

## Requirements
- R1: Select code 000 gives the sum of A and B, truncated to 16 bits (wraps modulo 2^16, no carry output).
- R2: Select code 001 gives A minus B, truncated to 16 bits (wraps modulo 2^16, no borrow output).
- R3: Select code 010 gives the bitwise AND of A and B.
- R4: Select code 011 gives the bitwise OR of A and B.
- R5: Select code 100 gives a 16-bit word with exactly one bit set, at bit position A[3:0]. A[15:4] and all of B have no effect on the result.
- R6: Select code 101 gives 16'h0001 when A is less than B, with both read as unsigned values, and 16'h0000 otherwise. Bits 15:1 are always zero.
- R7: Select codes 110 and 111 give a result of 16'h0000.
- R8: The zero flag is 1 exactly when the 16-bit result is 16'h0000. This holds for every select code.
- R9: Under select code 001, the zero flag is 1 if and only if A equals B. The control path relies on this for equal and not-equal branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select code |
| a_i | input | 16 | First operand (A) |
| b_i | input | 16 | Second operand (B) |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench applies every select code to every pairing of two operand sets. The first set is the sixteen small values 0 to 15, which run decode through every bit position. The second set is a group of edge words: all ones, the top bit alone, the largest positive value with the top bit clear, and mixed patterns. Equal operand pairs tell a correct equality test apart from a near miss under subtract. Pairs that straddle the top bit tell an unsigned comparison apart from a signed one. The edge words carry wide upper bits into A, so a decode that wrongly uses those bits, or that looks at B at all, gives a different result from the expected one.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_DEC   = 3'b100,
        OP_SLT   = 3'b101,
        OP_SPR6  = 3'b110,
        OP_SPR7  = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu6_addsub.sv
// Shared adder: subtract is A + ~B + 1. The carry out (1 = no borrow)
// also feeds the unsigned less-than result.
module alu6_addsub #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    localparam int unsigned EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic [EXT_W-1:0] full;

    always_comb begin
        b_eff = b_i ^ {WIDTH{sub_i}};
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
    end

    assign sum_o   = full[WIDTH-1:0];
    assign carry_o = full[EXT_W-1];

endmodule

// File: rtl/alu6_bitwise.sv
// Bitwise functions and the one-hot decode of the low bits of A.
module alu6_bitwise #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] dec_o
);

    localparam int unsigned IDX_W = $clog2(WIDTH);

    logic [IDX_W-1:0] idx;
    assign idx = a_i[IDX_W-1:0];

    assign and_o = a_i & b_i;
    assign or_o  = a_i | b_i;

    // One comparator per result bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_dec
        assign dec_o[g] = (idx == IDX_W'(g));
    end

endmodule

// File: rtl/alu6_core.sv
module alu6_core
    import alu6_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);

    alu_op_e          op;
    logic             use_sub;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] dec_w;
    logic [WIDTH-1:0] res;

    assign op = alu_op_e'(op_i);

    // Subtract and set-on-less share the adder in its inverting form.
    assign use_sub = (op == OP_SUB) || (op == OP_SLT);

    alu6_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (use_sub),
        .sum_o   (sum),
        .carry_o (carry)
    );

    alu6_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i   (a_i),
        .b_i   (b_i),
        .and_o (and_w),
        .or_o  (or_w),
        .dec_o (dec_w)
    );

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_SUB:  res = sum;
            OP_AND:  res = and_w;
            OP_OR:   res = or_w;
            OP_DEC:  res = dec_w;
            OP_SLT:  res = {{(WIDTH-1){1'b0}}, ~carry};
            OP_SPR6,
            OP_SPR7: res = '0;
            default: res = '0;
        endcase
    end

    assign result_o = res;
    assign zero_o   = ~|res;

endmodule

// File: rtl/alu6_checker.sv
module alu6_checker
    import alu6_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o
);

    localparam int unsigned IDX_W = $clog2(WIDTH);

    always_comb begin
        if (op_i == OP_ADD) begin
            a_r1_add_inverse: assert (WIDTH'(result_o - b_i) == a_i)
                else $error("R1 add result does not invert");
        end
        if (op_i == OP_SUB) begin
            a_r2_sub_inverse: assert (WIDTH'(result_o + b_i) == a_i)
                else $error("R2 sub result does not invert");
            a_r9_eq_branch: assert (zero_o == (a_i == b_i))
                else $error("R9 zero flag disagrees with equality");
        end
        if (op_i == OP_AND) begin
            a_r3_and_subset: assert (((result_o & ~a_i) == '0) && ((result_o & ~b_i) == '0))
                else $error("R3 AND result has extra bits");
        end
        if (op_i == OP_OR) begin
            a_r4_or_superset: assert (((result_o & a_i) == a_i) && ((result_o & b_i) == b_i))
                else $error("R4 OR result misses bits");
        end
        if (op_i == OP_DEC) begin
            a_r5_decode_onehot: assert (($countones(result_o) == 1) && result_o[a_i[IDX_W-1:0]])
                else $error("R5 decode not one-hot at A index");
        end
        if (op_i == OP_SLT) begin
            a_r6_slt_lsb_only: assert (result_o[WIDTH-1:1] == '0)
                else $error("R6 set-on-less upper bits set");
        end
        if ((op_i == OP_SPR6) || (op_i == OP_SPR7)) begin
            a_r7_spare_zero: assert ((result_o == '0) && zero_o)
                else $error("R7 spare code not zero");
        end
    end

endmodule

bind alu6_core alu6_checker #(.WIDTH(WIDTH)) u_alu6_checker (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/test_alu6_core.sv
module test_alu6_core;

    localparam int W = 16;
    localparam int NVEC = 24;

    logic         clk = 1'b0;
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    alu6_core #(.WIDTH(W)) i_alu6_core (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .result_o (res),
        .zero_o   (zero)
    );

    function automatic logic [W-1:0] vec(input int k);
        if (k < 16) return W'(k);
        case (k)
            16: return 16'hFFFF;
            17: return 16'h8000;
            18: return 16'h7FFF;
            19: return 16'h0010;
            20: return 16'hFFF0;
            21: return 16'h1234;
            22: return 16'hABCD;
            default: return 16'h00FF;
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [2:0] o,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
        case (o)
            3'b000: return W'(x + y);
            3'b001: return W'(x - y);
            3'b010: return x & y;
            3'b011: return x | y;
            3'b100: return W'(1) << x[3:0];
            3'b101: return (x < y) ? W'(1) : W'(0);
            default: return '0;
        endcase
    endfunction

    function automatic string tag(input logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100: return "R5";
            3'b101: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] e;
        @(negedge clk);
        op = o; a = x; b = y;
        #5;
        e = model(o, x, y);
        check(tag(o), res, e);
        check("R8", W'(zero), W'(e == '0));
        if (o == 3'b001) check("R9", W'(zero), W'(x == y));
    endtask

    initial begin
        op = '0; a = '0; b = '0;
        #15;
        // initial all-zero inputs: add of zeros gives zero, flag high (R1, R8)
        check("R1", res, '0);
        check("R8", W'(zero), W'(1));
        for (int o = 0; o < 8; o++) begin
            for (int i = 0; i < NVEC; i++) begin
                for (int j = 0; j < NVEC; j++) begin
                    apply(3'(o), vec(i), vec(j));
                end
            end
        end
        // R5: upper A bits and B have no effect on decode
        apply(3'b100, 16'hFFF3, 16'h0000);
        apply(3'b100, 16'h0003, 16'hFFFF);
        // R6: unsigned, not signed, comparison
        apply(3'b101, 16'h7FFF, 16'h8000);
        apply(3'b101, 16'h8000, 16'h7FFF);
        // R2/R9: wrap on borrow and equal operands
        apply(3'b001, 16'h0000, 16'h0001);
        apply(3'b001, 16'hBEEF, 16'hBEEF);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule